// File: doc/BRIEF.md
# Pipelined 8-bit Accumulator Processor Core

This block is a small processor with separate program and data memories. It finishes one instruction every clock. Each instruction word holds an opcode byte in its upper half and an 8-bit operand (called D here) in its lower half. The core keeps four 8-bit registers: an accumulator, two address registers (an X register for the low address byte and a Y register for the high one), and an output register that drives an 8-bit output bus. X and Y cannot be read by the program. Their only use is to form data-memory addresses.

Each opcode byte splits into three fixed fields. The top three bits choose the operation. The middle three bits choose the addressing mode, or the branch condition for a jump. The bottom two bits choose the value placed on the internal data bus. The core has a two-stage pipeline: one instruction is fetched while the previous one executes. Because of this, the instruction placed directly after any jump always executes.

The program memory and the data memory both return data in the same cycle as the address. The surrounding system supplies the memories, their contents and the software.

Top module: `cpu_core`

## Requirements
- R1: While reset is high, the fetch address, the accumulator, X, Y and the output bus are all cleared to zero. The first instruction slot after reset executes as a no-op (opcode 0x02), and the data write enable stays low.
- R2: The fetch address advances by one every clock unless a jump is taken. The instruction word is {opcode[7:0], D[7:0]}.
- R3: Opcode bits 7:5 choose the operation. 000 loads the bus value. 001 is AND with the accumulator, 010 is OR and 011 is XOR. 100 adds the bus value to the accumulator and 101 subtracts it, both modulo 256. 110 is a store and 111 is a jump.
- R4: Opcode bits 1:0 choose the bus value: 00 is D, 01 is the data-memory read data, and 10 is the accumulator.
- R5: For non-jump instructions, opcode bits 4:2 choose the address and the destination. 000: address D, result to the accumulator. 001: address {0,X}, to the accumulator. 010: address {Y,D}, to the accumulator. 011: address {Y,X}, to the accumulator. 100: address D, to X. 101: address D, to Y. 110: address D, to the output register. 111: address {Y,X}, to the output register.
- R6: Mode 111 increments X by one after the access.
- R7: A store raises the write enable for one cycle and writes the bus value to the mode's address. It never changes the accumulator or the output register. In modes 100 and 101 it also loads the bus value into X or Y.
- R8: For a jump, opcode bits 4:2 give the condition on the accumulator. 000 and 111 are always taken. 001 is taken when the accumulator is greater than zero, 010 when it is below zero, and 011 when it is non-zero. 100 is taken when it is zero, 101 when bit 7 is 0, and 110 when it is less than or equal to zero. "Above" and "below" zero treat the accumulator as a signed value.
- R9: The low byte of the jump target is the bus value. The high byte comes from Y for condition 000, and from the current fetch address for all other conditions.
- R10: The instruction right after a jump always executes, whether or not the jump is taken. The instruction after that one is skipped when the jump is taken.
- R11: A Fibonacci program that keeps a and b in data memory and loops on accumulator bit 7 emits 1,1,2,3,5,8,13,21,34,55,89,144 on the output bus. It then returns to address 0 exactly 110 clocks after it started.
- R12: Data-memory read data is used in the same cycle in which its address is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| romAddr | output | 16 | Program memory fetch address |
| romData | input | 16 | Instruction word for romAddr |
| ramAddr | output | 16 | Data memory address |
| ramRdata | input | 8 | Data memory read data for ramAddr |
| ramWdata | output | 8 | Data memory write data |
| ramWe | output | 1 | Data memory write enable |
| outBus | output | 8 | Output register |

## Verification
The bench targets delay slots. It places a store in the slot after each jump, so a core that squashed the slot loses an expected write. It places a second store after each taken jump, so a core that failed to redirect in time produces an extra write that no one expects. Stores are checked to leave the accumulator and the output register untouched, and stores through the X mode are checked to load X; a core that muted X, or forgot to mute the accumulator, would send later stores to the wrong address or with the wrong data. The Fibonacci run checks both the sequence on the output bus and the exact 110-clock loop length, so a lost or extra pipeline bubble shows up as a changed count.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;

  typedef enum logic [2:0] {
    OP_LD  = 3'b000,
    OP_AND = 3'b001,
    OP_OR  = 3'b010,
    OP_XOR = 3'b011,
    OP_ADD = 3'b100,
    OP_SUB = 3'b101,
    OP_ST  = 3'b110,
    OP_JMP = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'b00,
    SRC_RAM = 2'b01,
    SRC_AC  = 2'b10,
    SRC_ALT = 2'b11
  } busSrc_e;

  typedef enum logic [1:0] {
    ADR_D,
    ADR_X,
    ADR_YD,
    ADR_YX
  } adrSel_e;

  typedef struct packed {
    opcode_e    aluOp;
    busSrc_e    busSrc;
    adrSel_e    adrSel;
    logic       acWe;
    logic       outWe;
    logic       xWe;
    logic       yWe;
    logic       xInc;
    logic       ramWe;
    logic       isJump;
    logic [2:0] cond;
  } ctrl_t;

  localparam logic [7:0] OPC_NOP = 8'h02;

endpackage

// File: rtl/cpu_core_fetch.sv
module cpu_core_fetch
  import cpu_core_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = 8 + DW,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] romData,
  input  logic          taken,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic [7:0]    opc,
  output logic [DW-1:0] operand
);

  logic [IW-1:0] ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= {OPC_NOP, {DW{1'b0}}};
    end else begin
      ir <= romData;
      pc <= taken ? target : AW'(pc + 1'b1);
    end
  end

  assign opc     = ir[IW-1:DW];
  assign operand = ir[DW-1:0];

  // R1: reset parks the fetch at 0 with a no-op waiting to execute
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0 && opc == OPC_NOP));

  // R2: sequential fetch when no jump is taken
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc == AW'($past(pc) + 1'b1));

  // R10: a taken jump redirects the fetch after the delay slot is fetched
  a_r10_redirect: assert property (@(posedge clk) disable iff (rst)
    taken |=> pc == $past(target));

endmodule

// File: rtl/cpu_core_ctrl.sv
module cpu_core_ctrl
  import cpu_core_pkg::*;
(
  input  logic [7:0] opc,
  output ctrl_t      ctl
);

  opcode_e    op;
  logic [2:0] mode;

  assign op   = opcode_e'(opc[7:5]);
  assign mode = opc[4:2];

  always_comb begin
    ctl        = '0;
    ctl.aluOp  = op;
    ctl.busSrc = busSrc_e'(opc[1:0]);
    ctl.cond   = mode;
    ctl.isJump = (op == OP_JMP);
    ctl.adrSel = ADR_D;

    case (mode)
      3'b000: begin ctl.adrSel = ADR_D;  ctl.acWe  = 1'b1; end
      3'b001: begin ctl.adrSel = ADR_X;  ctl.acWe  = 1'b1; end
      3'b010: begin ctl.adrSel = ADR_YD; ctl.acWe  = 1'b1; end
      3'b011: begin ctl.adrSel = ADR_YX; ctl.acWe  = 1'b1; end
      3'b100: begin ctl.adrSel = ADR_D;  ctl.xWe   = 1'b1; end
      3'b101: begin ctl.adrSel = ADR_D;  ctl.yWe   = 1'b1; end
      3'b110: begin ctl.adrSel = ADR_D;  ctl.outWe = 1'b1; end
      default: begin
        ctl.adrSel = ADR_YX;
        ctl.outWe  = 1'b1;
        ctl.xInc   = 1'b1;
      end
    endcase

    if (op == OP_ST) begin
      // X and Y loads stay enabled on purpose
      ctl.acWe  = 1'b0;
      ctl.outWe = 1'b0;
      ctl.ramWe = 1'b1;
    end

    if (op == OP_JMP) begin
      ctl.acWe   = 1'b0;
      ctl.outWe  = 1'b0;
      ctl.xWe    = 1'b0;
      ctl.yWe    = 1'b0;
      ctl.xInc   = 1'b0;
      ctl.adrSel = ADR_D;
    end
  end

endmodule

// File: rtl/cpu_core_dp.sv
module cpu_core_dp
  import cpu_core_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctl,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] fetchPage,
  input  logic [DW-1:0] ramRdata,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  output logic          ramWe,
  output logic [DW-1:0] outBus,
  output logic          taken,
  output logic [AW-1:0] target
);

  logic [DW-1:0] acReg, xReg, yReg, outReg;
  logic [DW-1:0] busVal, aluRes;
  logic          acZero, acNeg, condOk;

  always_comb begin
    case (ctl.busSrc)
      SRC_RAM: busVal = ramRdata;
      SRC_AC:  busVal = acReg;
      default: busVal = operand;
    endcase
  end

  always_comb begin
    case (ctl.aluOp)
      OP_AND:  aluRes = acReg & busVal;
      OP_OR:   aluRes = acReg | busVal;
      OP_XOR:  aluRes = acReg ^ busVal;
      OP_ADD:  aluRes = DW'(acReg + busVal);
      OP_SUB:  aluRes = DW'(acReg - busVal);
      default: aluRes = busVal;
    endcase
  end

  always_comb begin
    case (ctl.adrSel)
      ADR_X:   ramAddr = {{DW{1'b0}}, xReg};
      ADR_YD:  ramAddr = {yReg, operand};
      ADR_YX:  ramAddr = {yReg, xReg};
      default: ramAddr = {{DW{1'b0}}, operand};
    endcase
  end

  assign acZero = (acReg == '0);
  assign acNeg  = acReg[DW-1];

  always_comb begin
    case (ctl.cond)
      3'b001:  condOk = !acZero && !acNeg;
      3'b010:  condOk = acNeg;
      3'b011:  condOk = !acZero;
      3'b100:  condOk = acZero;
      3'b101:  condOk = !acNeg;
      3'b110:  condOk = acNeg || acZero;
      default: condOk = 1'b1;
    endcase
  end

  assign taken    = ctl.isJump && condOk;
  assign target   = (ctl.cond == 3'b000) ? {yReg, busVal} : {fetchPage, busVal};
  assign ramWdata = busVal;
  assign ramWe    = ctl.ramWe;
  assign outBus   = outReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      acReg  <= '0;
      xReg   <= '0;
      yReg   <= '0;
      outReg <= '0;
    end else begin
      if (ctl.acWe)  acReg  <= aluRes;
      if (ctl.outWe) outReg <= aluRes;
      if (ctl.yWe)   yReg   <= aluRes;
      if (ctl.xWe)        xReg <= aluRes;
      else if (ctl.xInc)  xReg <= DW'(xReg + 1'b1);
    end
  end

  // R7: a store leaves the accumulator and output register as they were
  a_r7_store_keeps_ac_out: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluOp == OP_ST) |=> ($stable(acReg) && $stable(outReg)));

  // R6: the post-increment mode advances X by one
  a_r6_x_advance: assert property (@(posedge clk) disable iff (rst)
    ctl.xInc |=> xReg == DW'($past(xReg) + 1'b1));

  // R3: subtraction into the accumulator wraps modulo 2^DW
  a_r3_sub_wraps: assert property (@(posedge clk) disable iff (rst)
    (ctl.acWe && ctl.aluOp == OP_SUB) |=> acReg == DW'($past(acReg) - $past(busVal)));

  // R8: a jump never writes data memory or any register
  a_r8_jump_quiet: assert property (@(posedge clk) disable iff (rst)
    ctl.isJump |=> ($stable(acReg) && $stable(xReg) && $stable(yReg) && $stable(outReg)));

  // R7: write enable only on store cycles
  a_r7_we_only_store: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (ctl.aluOp == OP_ST));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_core_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW,
  localparam int IW = 8 + DW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] romAddr,
  input  logic [IW-1:0] romData,
  output logic [AW-1:0] ramAddr,
  input  logic [DW-1:0] ramRdata,
  output logic [DW-1:0] ramWdata,
  output logic          ramWe,
  output logic [DW-1:0] outBus
);

  logic [7:0]    opc;
  logic [DW-1:0] operand;
  logic          taken;
  logic [AW-1:0] target;
  logic [AW-1:0] pc;
  ctrl_t         ctl;

  cpu_core_fetch #(.DW(DW)) u_fetch (
    .clk(clk), .rst(rst), .romData(romData), .taken(taken),
    .target(target), .pc(pc), .opc(opc), .operand(operand)
  );

  cpu_core_ctrl u_ctrl (.opc(opc), .ctl(ctl));

  cpu_core_dp #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .operand(operand),
    .fetchPage(pc[AW-1:DW]), .ramRdata(ramRdata), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramWe(ramWe), .outBus(outBus),
    .taken(taken), .target(target)
  );

  assign romAddr = pc;

  // R10: after a taken jump the next fetch address is the target
  a_r10_target_follows: assert property (@(posedge clk) disable iff (rst)
    taken |=> romAddr == $past(target));

endmodule

// File: tb/cpu_core_test.sv
module cpu_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] romAddr, romData, ramAddr;
  logic [7:0]  ramRdata, ramWdata, outBus;
  logic        ramWe;

  logic [15:0] rom [256];
  logic [7:0]  ram [1024];

  int nChecks = 0;
  int nFail   = 0;
  int phase   = 0;

  logic [23:0] expWr[$];
  logic [7:0]  expOut[$];

  always #5 clk = ~clk;

  assign romData  = rom[romAddr[7:0]];
  assign ramRdata = ram[ramAddr[9:0]];

  always @(posedge clk) if (ramWe) ram[ramAddr[9:0]] <= ramWdata;

  cpu_core uut (
    .clk(clk), .rst(rst), .romAddr(romAddr), .romData(romData),
    .ramAddr(ramAddr), .ramRdata(ramRdata), .ramWdata(ramWdata),
    .ramWe(ramWe), .outBus(outBus)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0200;
    for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    rom[a] = w;
  endtask

  // monitor state
  bit         fibSeen0 = 0, fibDone = 0, prevAtC = 0;
  int         cyc = 0;
  logic [7:0] prevOut = 8'h00;
  int         hiErrs = 0;

  always @(negedge clk) begin
    if (!rst && phase == 1) begin
      if (fibSeen0) cyc++;
      if (prevAtC && !fibDone) begin
        if (expOut.size() == 0) chk(0, "R11 extra OUT update", {24'h0, outBus}, 0);
        else begin
          logic [7:0] e;
          e = expOut.pop_front();
          chk(outBus == e, "R11 fibonacci OUT", {24'h0, outBus}, {24'h0, e});
        end
      end
      if (romAddr == 16'h0000) begin
        if (!fibSeen0) begin fibSeen0 = 1; cyc = 0; end
        else if (!fibDone) begin
          fibDone = 1;
          chk(cyc == 110, "R11 loop length", cyc, 110);
        end
      end
      prevAtC = (romAddr == 16'h000c);
    end
    if (!rst && phase == 2) begin
      if (romAddr[15:8] != 8'h00) hiErrs++;
      if (ramWe) begin
        if (expWr.size() == 0)
          chk(0, "R10 unexpected write (skipped slot ran)", {8'h0, ramAddr, ramWdata}, 0);
        else begin
          logic [23:0] e;
          e = expWr.pop_front();
          chk({ramAddr, ramWdata} == e, "R7 store addr/data", {8'h0, ramAddr, ramWdata}, {8'h0, e});
        end
      end
      if (outBus != prevOut) begin
        if (expOut.size() == 0) chk(0, "R7 unexpected OUT change", {24'h0, outBus}, {24'h0, prevOut});
        else begin
          logic [7:0] e;
          e = expOut.pop_front();
          chk(outBus == e, "R5 OUT value", {24'h0, outBus}, {24'h0, e});
        end
        prevOut = outBus;
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // ---------- Fibonacci program (R11, R12, R10) ----------
    clearMem();
    put(8'h00, 16'h0000); put(8'h01, 16'hC200); put(8'h02, 16'h0001);
    put(8'h03, 16'hFC0A); put(8'h04, 16'h0200); put(8'h05, 16'h0100);
    put(8'h06, 16'hC202); put(8'h07, 16'h0101); put(8'h08, 16'hC200);
    put(8'h09, 16'h8102); put(8'h0a, 16'hC201); put(8'h0b, 16'h1A00);
    put(8'h0c, 16'hF405); put(8'h0d, 16'h0200); put(8'h0e, 16'hFC00);
    put(8'h0f, 16'h0200);
    foreach (expOut[i]) expOut.delete(i);
    expOut = '{8'd1, 8'd1, 8'd2, 8'd3, 8'd5, 8'd8, 8'd13, 8'd21, 8'd34, 8'd55, 8'd89, 8'd144};
    rst = 1'b1;
    phase = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(romAddr == 16'h0000, "R1 fetch address in reset", {16'h0, romAddr}, 0);
    chk(ramWe == 1'b0, "R1 write enable in reset", {31'h0, ramWe}, 0);
    chk(outBus == 8'h00, "R1 OUT in reset", {24'h0, outBus}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(ramWe == 1'b0 && romAddr == 16'h0000, "R1 first slot is a no-op", {15'h0, ramWe, romAddr}, 0);
    @(negedge clk);
    chk(romAddr == 16'h0001, "R2 fetch advances", {16'h0, romAddr}, 1);
    repeat (200) begin
      @(negedge clk);
      if (fibDone) break;
    end
    chk(fibDone == 1'b1, "R11 returned to start", {31'h0, fibDone}, 1);
    chk(expOut.size() == 0, "R11 all values emitted", expOut.size(), 0);
    chk(outBus == 8'd144, "R11 final OUT", {24'h0, outBus}, 144);

    // ---------- instruction mix program ----------
    @(posedge clk); #1 rst = 1'b1; phase = 0;
    clearMem();
    put(8'h00, 16'h005C); put(8'h01, 16'h200F); put(8'h02, 16'hC210);
    put(8'h03, 16'h40A0); put(8'h04, 16'h60FF); put(8'h05, 16'hC211);
    put(8'h06, 16'hA054); put(8'h07, 16'h8003); put(8'h08, 16'hC212);
    put(8'h09, 16'hD220); put(8'h0a, 16'h1440); put(8'h0b, 16'hCE00);
    put(8'h0c, 16'h1899); put(8'h0d, 16'hC214); put(8'h0e, 16'h8110);
    put(8'h0f, 16'hDE00); put(8'h10, 16'hCE00); put(8'h11, 16'hCA55);
    put(8'h12, 16'hC600); put(8'h13, 16'h0000); put(8'h14, 16'hEC40);
    put(8'h15, 16'h0001); put(8'h16, 16'hF040); put(8'h17, 16'hC216);
    put(8'h18, 16'hEC20); put(8'h19, 16'hC217); put(8'h1a, 16'hC218);
    put(8'h20, 16'h0080); put(8'h21, 16'hF430); put(8'h22, 16'h0200);
    put(8'h23, 16'hE828); put(8'h24, 16'h8001); put(8'h25, 16'hC219);
    put(8'h26, 16'hC219); put(8'h27, 16'hC219); put(8'h28, 16'hC21A);
    put(8'h29, 16'h1A00); put(8'h2a, 16'h1400); put(8'h2b, 16'hE030);
    put(8'h2c, 16'hC21B); put(8'h2d, 16'hC21C); put(8'h30, 16'hFC30);
    put(8'h31, 16'h0200);
    // R3 and/or/xor/add/sub, R4 bus sources, R5 modes, R6 X++, R7 store side effects,
    // R8 conditions, R9 far target, R10 delay slots, R12 same-cycle read
    expWr = '{ {16'h0010, 8'h0C}, {16'h0011, 8'h53}, {16'h0012, 8'h02},
               {16'h0020, 8'h02}, {16'h4002, 8'h02}, {16'h0014, 8'h02},
               {16'h4002, 8'h0E}, {16'h4003, 8'h0E}, {16'h4055, 8'h0E},
               {16'h0003, 8'h0E}, {16'h0016, 8'h01}, {16'h0017, 8'h01},
               {16'h001A, 8'h81}, {16'h001B, 8'h81} };
    expOut = '{8'h99, 8'h81};
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(outBus == 8'h00, "R1 reset clears OUT", {24'h0, outBus}, 0);
    prevOut = 8'h00;
    phase = 2;
    @(posedge clk); #1 rst = 1'b0;
    repeat (90) @(negedge clk);
    chk(expWr.size() == 0, "R10 delay-slot stores all seen", expWr.size(), 0);
    chk(expOut.size() == 0, "R5 OUT updates all seen", expOut.size(), 0);
    chk(outBus == 8'h81, "R7 OUT kept across stores", {24'h0, outBus}, 32'h81);
    chk(romAddr == 16'h0030 || romAddr == 16'h0031, "R9 far jump landed in loop",
        {16'h0, romAddr}, 32'h30);
    chk(hiErrs == 0, "R9 fetch page stayed zero", hiErrs, 0);
    finishRun();
  end

endmodule